// File: doc/BRIEF.md
# Legacy PCI Interrupt Router with Software Autodetection

This block collects the four level-sensitive interrupt pins of every device slot on a conventional PCI bus. It folds them onto four host interrupt lines. Two routings exist. The first is a rotated mapping that follows the board wiring. The second is a legacy mapping in which pin n of every slot lands on host line n. Older guest software assumes the legacy mapping.

The block chooses between the two routings by snooping configuration writes. While its mapping mode is still undecided, the block classifies the first write to a device's interrupt-line register. The classification uses the written value and the target slot. The result settles the mode, and the mode stays fixed until the next reset. A reset-time mode input lets the integrator force either outcome, and a board strap selects the rotation constant. The current mode is visible on a debug output.

Top module: `pci_irq_router`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the mode loads `reset_mode`, and the value 3 loads as 0. Mode encodings on `mode_dbg` are 0 = undecided, 1 = legacy and 2 = fixed.
- R2: A classification happens only at a rising edge where all of the following hold: the mode is 0, `alt_board` is 0, `cfg_wr` is 1, and `cfg_addr[7:0]` equals 0x3C. The resulting mode shows on `mode_dbg` after that edge.
- R3: The slot number is `cfg_addr[15:11]`, and classification uses the slot modulo 4 (`cfg_addr[12:11]`). A written value of 27 gives mode 1, except when the slot modulo 4 is 2; in that case the mode stays 0.
- R4: A written value equal to 27 + (slot mod 4) or 91 + (slot mod 4) gives mode 1. Any other value, including any value of 256 or more, gives mode 2.
- R5: Once the mode is 1 or 2, no configuration write changes it until reset.
- R6: In mode 1, pin p (0..3) of any slot drives `host_irq[p]`.
- R7: In modes 0 and 2, pin p of slot s drives `host_irq[(s + p + k) mod 4]`. Here k is 2 when `alt_board` is 0 and 3 when it is 1.
- R8: `pin_lvl[4*s + p]` is pin p of slot s. Each host line is the OR of every pin routed to it. The lines follow the pins combinationally, and all pins low gives all lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_mode | input | 2 | Mode loaded during reset |
| alt_board | input | 1 | Board variant strap; 1 selects rotation 3 and disables detection |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (16) | Configuration address; [15:8] device/function, [7:0] register offset |
| cfg_wdata | input | DATA_W (32) | Configuration write data |
| pin_lvl | input | 4*NSLOT (128) | Interrupt pin levels, four per slot |
| host_irq | output | 4 | Host interrupt lines |
| mode_dbg | output | 2 | Current mapping mode |

## Verification
The mode register is the only state. A classifying write that is presented before a rising edge shows on `mode_dbg` after that edge. The bench therefore drives each write on a falling edge, holds it across one rising edge, and reads the mode at the next falling edge. Host lines have no latency behind the pins. The bench changes the pin levels on a falling edge and samples the lines a moment later in the same half cycle. A change of mode affects the routing from the edge that stores the mode onward.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  typedef enum logic [1:0] {
    MODE_UNSET  = 2'd0,
    MODE_LEGACY = 2'd1,
    MODE_FIXED  = 2'd2
  } map_mode_e;

  localparam logic [7:0] LINE_REG_OFS = 8'h3C;
  localparam logic [7:0] LEGACY_BASE  = 8'd27;
  localparam logic [7:0] SHIFTED_BASE = 8'd91;

  // Decide what an interrupt-line value says about the guest's expectations.
  function automatic map_mode_e classify_line(input logic [1:0] slot4,
                                              input logic [7:0] val);
    logic [7:0] near_v;
    logic [7:0] far_v;
    near_v = LEGACY_BASE + {6'd0, slot4};
    far_v  = SHIFTED_BASE + {6'd0, slot4};
    if (val == LEGACY_BASE)
      return (slot4 == 2'd2) ? MODE_UNSET : MODE_LEGACY;
    else if (val == near_v || val == far_v)
      return MODE_LEGACY;
    else
      return MODE_FIXED;
  endfunction

  // Host line index for one pin of one slot.
  function automatic logic [1:0] route_idx(input logic [1:0] slot4,
                                           input logic [1:0] pin,
                                           input logic       legacy,
                                           input logic       alt);
    logic [1:0] rot;
    rot = alt ? 2'd3 : 2'd2;
    return legacy ? pin : (slot4 + pin + rot);
  endfunction

endpackage

// File: rtl/irq_mode_detect.sv
module irq_mode_detect
  import pirq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reset_mode,
  input  logic              alt_board,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output map_mode_e         mode_q
);

  localparam int SLOT_LSB = 11;

  logic       wr_line;
  logic       detect_fire;
  logic [1:0] slot4;
  logic [7:0] val8;
  map_mode_e  verdict;
  map_mode_e  boot_mode;

  assign wr_line     = cfg_wr && (cfg_addr[7:0] == LINE_REG_OFS);
  assign detect_fire = wr_line && !alt_board && (mode_q == MODE_UNSET);
  assign slot4       = cfg_addr[SLOT_LSB+1:SLOT_LSB];
  // Values that do not fit in a byte can never match a legacy pattern.
  assign val8        = ((cfg_wdata >> 8) == '0) ? cfg_wdata[7:0] : 8'hFF;
  assign verdict     = classify_line(slot4, val8);
  assign boot_mode   = (reset_mode == 2'd3) ? MODE_UNSET : map_mode_e'(reset_mode);

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode_q <= boot_mode;
    else if (detect_fire)
      mode_q <= verdict;
  end

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_UNSET) |=> (mode_q == $past(mode_q)));

  p_alt_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_board && mode_q == MODE_UNSET) |=> (mode_q == MODE_UNSET));

  p_other_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_line && mode_q == MODE_UNSET) |=> (mode_q == MODE_UNSET));

  p_slot2_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (detect_fire && slot4 == 2'd2 && cfg_wdata == DATA_W'(27))
      |=> (mode_q == MODE_UNSET));

endmodule

// File: rtl/irq_pin_route.sv
module irq_pin_route
  import pirq_pkg::*;
#(
  parameter int NSLOT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [4*NSLOT-1:0] pin_lvl,
  input  logic               legacy,
  input  logic               alt_board,
  output logic [3:0]         host_irq
);

  logic [3:0] contrib [NSLOT];
  logic [3:0] pin_any;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [3:0] c;
    always_comb begin
      c = 4'h0;
      for (int p = 0; p < 4; p++)
        if (pin_lvl[4*s+p])
          c[route_idx(2'(s), 2'(p), legacy, alt_board)] = 1'b1;
    end
    assign contrib[s] = c;
  end

  always_comb begin
    host_irq = 4'h0;
    pin_any  = 4'h0;
    for (int s = 0; s < NSLOT; s++) begin
      host_irq = host_irq | contrib[s];
      pin_any  = pin_any | pin_lvl[4*s +: 4];
    end
  end

  p_legacy_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    legacy |-> ((host_irq & ~pin_any) == 4'h0));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_lvl == '0) |-> (host_irq == 4'h0));

  p_no_extra_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(host_irq) <= $countones(pin_lvl));

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pirq_pkg::*;
#(
  parameter int NSLOT  = 32,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         reset_mode,
  input  logic               alt_board,
  input  logic               cfg_wr,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic [4*NSLOT-1:0] pin_lvl,
  output logic [3:0]         host_irq,
  output logic [1:0]         mode_dbg
);

  map_mode_e mode_q;
  logic      legacy;

  irq_mode_detect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .reset_mode (reset_mode),
    .alt_board  (alt_board),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .mode_q     (mode_q)
  );

  assign legacy   = (mode_q == MODE_LEGACY);
  assign mode_dbg = mode_q;

  irq_pin_route #(.NSLOT(NSLOT)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_lvl   (pin_lvl),
    .legacy    (legacy),
    .alt_board (alt_board),
    .host_irq  (host_irq)
  );

endmodule

// File: tb/tb_pci_irq_router.sv
module tb_pci_irq_router;
  localparam int CLK_P = 10;
  localparam int NS    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    reset_mode = 2'd0;
  logic          alt_board = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [15:0]   cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [4*NS-1:0] pin_lvl = '0;
  logic [3:0]    host_irq;
  logic [1:0]    mode_dbg;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  pci_irq_router dut (
    .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode), .alt_board(alt_board),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pin_lvl(pin_lvl), .host_irq(host_irq), .mode_dbg(mode_dbg)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic alt);
    @(negedge clk);
    rst_n = 1'b0; reset_mode = m; alt_board = alt; cfg_wr = 1'b0; pin_lvl = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(input int slot, input logic [7:0] ofs, input logic [31:0] v,
                           input logic wr);
    @(negedge clk);
    cfg_addr = {slot[4:0], 3'd0, ofs}; cfg_wdata = v; cfg_wr = wr;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  function automatic int want_mode(input int s4, input int v);
    if (v == 27) return (s4 == 2) ? 0 : 1;
    if (v - 27 == s4 || v - 91 == s4) return 1;
    return 2;
  endfunction

  function automatic int want_line(input int s, input int p, input int md, input int alt);
    if (md == 1) return p;
    return (s + p + (alt ? 3 : 2)) % 4;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int vals[14] = '{27, 28, 29, 30, 31, 26, 91, 92, 93, 94, 95, 0, 200, 283};
    logic [31:0] rng;

    // R1: reset values, including the 3 -> 0 fold
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m), 1'b0);
      #1 chk("R1 reset mode", int'(mode_dbg), (m == 3) ? 0 : m);
      chk("R8 idle lines", int'(host_irq), 0);
    end

    // R3/R4: classification sweep over slot classes and values
    for (int s4 = 0; s4 < 4; s4++) begin
      for (int i = 0; i < 14; i++) begin
        int slot;
        slot = s4 + 4 * (i % 8);
        do_reset(2'd0, 1'b0);
        cfg_write(slot, 8'h3C, 32'(vals[i]), 1'b1);
        #1 chk((vals[i] == 27) ? "R3 classify" : "R4 classify",
               int'(mode_dbg), want_mode(s4, vals[i]));
      end
    end

    // R2: writes that must not classify
    do_reset(2'd0, 1'b0);
    cfg_write(1, 8'h3D, 32'd28, 1'b1);
    #1 chk("R2 other offset", int'(mode_dbg), 0);
    cfg_write(1, 8'h3C, 32'd28, 1'b0);
    #1 chk("R2 no strobe", int'(mode_dbg), 0);
    do_reset(2'd0, 1'b1);
    cfg_write(1, 8'h3C, 32'd28, 1'b1);
    #1 chk("R2 alt board", int'(mode_dbg), 0);
    cfg_write(1, 8'h3C, 32'd5, 1'b1);
    #1 chk("R2 alt board", int'(mode_dbg), 0);

    // R3: undecided after slot-2 value 27, later write still classifies
    do_reset(2'd0, 1'b0);
    cfg_write(6, 8'h3C, 32'd27, 1'b1);
    #1 chk("R3 slot2 keep", int'(mode_dbg), 0);
    cfg_write(1, 8'h3C, 32'd28, 1'b1);
    #1 chk("R3 later write", int'(mode_dbg), 1);

    // R5: stickiness
    cfg_write(0, 8'h3C, 32'd100, 1'b1);
    #1 chk("R5 legacy sticky", int'(mode_dbg), 1);
    do_reset(2'd0, 1'b0);
    cfg_write(0, 8'h3C, 32'd100, 1'b1);
    #1 chk("R5 fixed set", int'(mode_dbg), 2);
    cfg_write(0, 8'h3C, 32'd27, 1'b1);
    #1 chk("R5 fixed sticky", int'(mode_dbg), 2);
    do_reset(2'd1, 1'b0);
    cfg_write(3, 8'h3C, 32'd200, 1'b1);
    #1 chk("R5 preset legacy", int'(mode_dbg), 1);

    // R6/R7: single-pin routing sweep over modes and strap
    for (int md = 0; md < 3; md++) begin
      for (int alt = 0; alt < 2; alt++) begin
        do_reset(2'(md), 1'(alt));
        for (int s = 0; s < NS; s++) begin
          for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            pin_lvl = '0;
            pin_lvl[4*s+p] = 1'b1;
            #1 chk((md == 1) ? "R6 route" : "R7 route", int'(host_irq),
                   1 << want_line(s, p, md, alt));
          end
        end
      end
    end

    // R8: multi-pin OR combining
    rng = 32'h1234_5678;
    for (int md = 0; md < 3; md++) begin
      for (int alt = 0; alt < 2; alt++) begin
        do_reset(2'(md), 1'(alt));
        for (int k = 0; k < 20; k++) begin
          int exp;
          @(negedge clk);
          for (int w = 0; w < NS/8; w++) begin
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            pin_lvl[32*w +: 32] = (k % 3 == 0) ? (rng & 32'h0101_0010) : rng;
          end
          exp = 0;
          for (int b = 0; b < 4*NS; b++)
            if (pin_lvl[b]) exp |= 1 << want_line(b / 4, b % 4, md, alt);
          #1 chk("R8 or", int'(host_irq), exp);
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule